// File: doc/BRIEF.md
# Command and Status Configuration Word

This block holds the identification word and the combined command/status word of a configuration space header. Software reaches both through a small register port with a byte offset, write data, per-lane byte enables and registered read data. Command bits are stored and sent to the rest of the function as enable outputs. Status bits are either fixed at build time, taken from a live input, or latched from completion events.

Two status flags record failed completions that come back from the fabric. One records an unsupported-request completion and the other records a completer-abort completion. Each flag stays set until software writes a 1 to it. A legacy interrupt-pending input is shown as a status bit, and it drives the INTx output unless the command word's interrupt disable bit is set. Vendor and device identifiers come from strap inputs. Two build parameters are available. One marks the instance as the fabric-facing port, which holds both abort flags at zero. The other removes the capability-list indication.

Top module: `cfg_cmdsts_reg`

## Requirements
- R1: After reset, a read of offset 0x04 returns 0x00100000 when CAP_PRESENT=1. All command outputs and intx_out are 0.
- R2: A read of offset 0x00 returns {strap_device, strap_vendor}. Writes to offset 0x00 have no effect.
- R3: A cycle with cpl_valid=1 and cpl_status=3'b001 (unsupported request) sets bit 29 of offset 0x04. A cycle with cpl_status=3'b100 (completer abort) sets bit 28. The code 3'b000 (success) sets neither bit.
- R4: Bits 29 and 28 are cleared by a write to 0x04 with reg_be[3]=1 and a 1 in that bit position. Writing 0 to them, or writing with reg_be[3]=0, leaves them set.
- R5: If a completion event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R6: Bit 19 of offset 0x04 shows irq_pending as sampled on the previous clock edge. The interrupt disable bit does not change it.
- R7: intx_out is 1 exactly when the sampled interrupt status is 1 and bit 10 (interrupt disable) is 0.
- R8: Command bits 1 (mem_en), 2 (bus_master_en), 8 (serr_en) and 10 (interrupt disable) are read/write and reset to 0. Bits 1 and 2 are written only when reg_be[0]=1, and bits 8 and 10 only when reg_be[1]=1.
- R9: Reserved bits 31:30, 27:21, 18:11, 9, 7:3 and 0 always read 0 and ignore writes. Offsets other than 0x00 and 0x04 read as 0.
- R10: reg_rdata and reg_rvalid appear one cycle after reg_rd. reg_rvalid is 0 in cycles that follow no read.
- R11: With FABRIC_PORT=1, bits 29 and 28 stay 0 whatever completions arrive. With CAP_PRESENT=0, bit 20 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 8 | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte lane enables |
| reg_rdata | output | 32 | Read data, one cycle after reg_rd |
| reg_rvalid | output | 1 | Read data valid |
| cpl_valid | input | 1 | Completion status event strobe |
| cpl_status | input | 3 | Completion status code |
| irq_pending | input | 1 | Legacy interrupt pending |
| strap_vendor | input | 16 | Vendor identifier strap |
| strap_device | input | 16 | Device identifier strap |
| intx_out | output | 1 | Gated legacy interrupt |
| mem_en | output | 1 | Memory space enable |
| bus_master_en | output | 1 | Bus master enable |
| serr_en | output | 1 | System error reporting enable |

## Verification
The hardest case to reach from the ports is a completion event that lands in the same cycle as a write-1-to-clear on the same flag. The stimulus drives cpl_valid and reg_wr from the same falling edge so that both reach the same rising edge, and then reads the flag back. The fabric-port variant cannot be driven to a nonzero flag at all. A second instance built with FABRIC_PORT=1 and CAP_PRESENT=0 shares every input with the first and is checked after the same completion events.

// File: rtl/cmdsts_pkg.sv
package cmdsts_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned LANES  = DATA_W / 8;

  localparam logic [ADDR_W-1:0] OFS_IDENT  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CMDSTS = 8'h04;

  localparam int unsigned BIT_MEM    = 1;
  localparam int unsigned BIT_BME    = 2;
  localparam int unsigned BIT_SERR   = 8;
  localparam int unsigned BIT_INTDIS = 10;
  localparam int unsigned BIT_IRQSTS = 19;
  localparam int unsigned BIT_CAP    = 20;
  localparam int unsigned BIT_RTA    = 28;
  localparam int unsigned BIT_RMA    = 29;

  localparam logic [DATA_W-1:0] CMD_RW_MASK =
    (32'd1 << BIT_MEM) | (32'd1 << BIT_BME) | (32'd1 << BIT_SERR) | (32'd1 << BIT_INTDIS);

  typedef enum logic [2:0] {
    CPL_SUCCESS = 3'b000,
    CPL_UNSUPP  = 3'b001,
    CPL_CABORT  = 3'b100
  } cpl_code_e;

  localparam int unsigned NUM_FLAGS = 2;
endpackage

// File: rtl/cmdsts_w1c_flag.sv
module cmdsts_w1c_flag #(
  parameter bit ENABLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  generate
    if (ENABLE) begin : g_flag
      logic flag_d, flag_q;
      always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;  // set takes priority over clear
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
      end
      assign flag_o = flag_q;
    end else begin : g_tied
      logic unused_flag_in;
      assign unused_flag_in = set_i ^ clr_i ^ clk ^ rst_n;
      assign flag_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/cmdsts_rw_reg.sv
module cmdsts_rw_reg #(
  parameter int unsigned  WIDTH = 32,
  parameter logic [WIDTH-1:0] MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] bit_we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] unused_we;
  assign unused_we = (bit_we | wdata) & ~MASK;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (MASK[i]) begin : g_store
      logic bit_d, bit_q;
      always_comb begin
        bit_d = bit_q;
        if (bit_we[i]) bit_d = wdata[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_d;
      end
      assign q[i] = bit_q;
    end else begin : g_zero
      assign q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/cfg_cmdsts_reg.sv
module cfg_cmdsts_reg
  import cmdsts_pkg::*;
#(
  parameter bit FABRIC_PORT = 1'b0,
  parameter bit CAP_PRESENT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [LANES-1:0]  reg_be,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  input  logic              cpl_valid,
  input  logic [2:0]        cpl_status,
  input  logic              irq_pending,
  input  logic [15:0]       strap_vendor,
  input  logic [15:0]       strap_device,
  output logic              intx_out,
  output logic              mem_en,
  output logic              bus_master_en,
  output logic              serr_en
);
  logic              sel_cmdsts;
  logic [DATA_W-1:0] lane_mask;
  logic [DATA_W-1:0] cmd_we;
  logic [DATA_W-1:0] cmd_q;
  logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;
  logic              rma_q, rta_q;
  logic              irq_d, irq_q;
  logic              int_dis;
  logic [DATA_W-1:0] status_word;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_d;
  logic              rvalid_d;

  assign sel_cmdsts = reg_wr && (reg_addr == OFS_CMDSTS);

  always_comb begin
    for (int l = 0; l < int'(LANES); l++) lane_mask[l*8 +: 8] = {8{reg_be[l]}};
    cmd_we = sel_cmdsts ? lane_mask : '0;
  end

  cmdsts_rw_reg #(.WIDTH(DATA_W), .MASK(CMD_RW_MASK)) u_cmd (
    .clk(clk), .rst_n(rst_n), .bit_we(cmd_we), .wdata(reg_wdata), .q(cmd_q)
  );

  // flag 1: unsupported request (bit 29), flag 0: completer abort (bit 28)
  always_comb begin
    flag_set[1] = cpl_valid && (cpl_status == CPL_UNSUPP);
    flag_set[0] = cpl_valid && (cpl_status == CPL_CABORT);
    flag_clr[1] = sel_cmdsts && lane_mask[BIT_RMA] && reg_wdata[BIT_RMA];
    flag_clr[0] = sel_cmdsts && lane_mask[BIT_RTA] && reg_wdata[BIT_RTA];
  end

  for (genvar f = 0; f < int'(NUM_FLAGS); f++) begin : g_abort
    cmdsts_w1c_flag #(.ENABLE(!FABRIC_PORT)) u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(flag_set[f]), .clr_i(flag_clr[f]), .flag_o(flag_q[f])
    );
  end
  assign rma_q = flag_q[1];
  assign rta_q = flag_q[0];

  assign irq_d = irq_pending;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign int_dis       = cmd_q[BIT_INTDIS];
  assign intx_out      = irq_q && !int_dis;
  assign mem_en        = cmd_q[BIT_MEM];
  assign bus_master_en = cmd_q[BIT_BME];
  assign serr_en       = cmd_q[BIT_SERR];

  always_comb begin
    status_word          = cmd_q;
    status_word[BIT_RMA] = rma_q;
    status_word[BIT_RTA] = rta_q;
    status_word[BIT_CAP] = CAP_PRESENT;
    status_word[BIT_IRQSTS] = irq_q;
  end

  always_comb begin
    unique case (reg_addr)
      OFS_IDENT:  rd_mux = {strap_device, strap_vendor};
      OFS_CMDSTS: rd_mux = status_word;
      default:    rd_mux = '0;
    endcase
    rdata_d  = reg_rd ? rd_mux : reg_rdata;
    rvalid_d = reg_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rdata  <= rdata_d;
      reg_rvalid <= rvalid_d;
    end
  end
endmodule

// File: rtl/cmdsts_chk.sv
module cmdsts_chk
  import cmdsts_pkg::*;
#(
  parameter bit FABRIC_PORT = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [LANES-1:0]  reg_be,
  input logic              reg_rvalid,
  input logic              cpl_valid,
  input logic [2:0]        cpl_status,
  input logic              irq_pending,
  input logic              intx_out,
  input logic              rma_q,
  input logic              rta_q,
  input logic              int_dis
);
  // R3 unsupported-request completion latches the flag
  a_r3_rma_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!FABRIC_PORT && cpl_valid && cpl_status == CPL_UNSUPP) |=> rma_q);

  // R3 completer-abort completion latches the flag
  a_r3_rta_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!FABRIC_PORT && cpl_valid && cpl_status == CPL_CABORT) |=> rta_q);

  // R4 flag holds unless cleared through lane 3 with a 1
  a_r4_rma_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rma_q && !(reg_wr && reg_addr == OFS_CMDSTS && reg_be[3] && reg_wdata[BIT_RMA])) |=> rma_q);

  // R7 interrupt output needs a pending request one cycle back
  a_r7_intx_src: assert property (@(posedge clk) disable iff (!rst_n)
    intx_out |-> $past(irq_pending));

  // R7 disable bit masks the output
  a_r7_intx_mask: assert property (@(posedge clk) disable iff (!rst_n)
    int_dis |-> !intx_out);

  // R10 read valid follows the strobe by one cycle
  a_r10_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);
  a_r10_no_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_rvalid);

  // R11 fabric port never raises an abort flag
  always_comb begin
    if (rst_n && FABRIC_PORT) a_r11_fabric_quiet: assert (!rma_q && !rta_q);
  end
endmodule

bind cfg_cmdsts_reg cmdsts_chk #(.FABRIC_PORT(FABRIC_PORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rvalid(reg_rvalid),
  .cpl_valid(cpl_valid), .cpl_status(cpl_status), .irq_pending(irq_pending),
  .intx_out(intx_out), .rma_q(rma_q), .rta_q(rta_q), .int_dis(int_dis)
);

// File: tb/test_cfg_cmdsts_reg.sv
module test_cfg_cmdsts_reg;
  localparam logic [15:0] VEND = 16'h1B2E;
  localparam logic [15:0] DEVI = 16'hA5C3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_rdata, fab_rdata;
  logic        reg_rvalid, fab_rvalid;
  logic        cpl_valid = 1'b0;
  logic [2:0]  cpl_status = '0;
  logic        irq_pending = 1'b0;
  logic        intx_out, mem_en, bus_master_en, serr_en;
  logic        f_intx, f_mem, f_bme, f_serr;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  cfg_cmdsts_reg i_cfg_cmdsts_reg (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .cpl_valid(cpl_valid), .cpl_status(cpl_status), .irq_pending(irq_pending),
    .strap_vendor(VEND), .strap_device(DEVI), .intx_out(intx_out), .mem_en(mem_en),
    .bus_master_en(bus_master_en), .serr_en(serr_en));

  cfg_cmdsts_reg #(.FABRIC_PORT(1'b1), .CAP_PRESENT(1'b0)) i_cfg_cmdsts_reg_fab (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(fab_rdata), .reg_rvalid(fab_rvalid),
    .cpl_valid(cpl_valid), .cpl_status(cpl_status), .irq_pending(irq_pending),
    .strap_vendor(VEND), .strap_device(DEVI), .intx_out(f_intx), .mem_en(f_mem),
    .bus_master_en(f_bme), .serr_en(f_serr));

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [3:0]  be;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h04, 32'h0,         4'h0, 32'h0010_0000},  // R1
    '{1'b0, 8'h00, 32'h0,         4'h0, 32'hA5C3_1B2E},  // R2
    '{1'b1, 8'h04, 32'hFFFF_FFFF, 4'hF, 32'h0},
    '{1'b0, 8'h04, 32'h0,         4'h0, 32'h0010_0506},  // R8 R9
    '{1'b1, 8'h04, 32'h0,         4'h1, 32'h0},
    '{1'b0, 8'h04, 32'h0,         4'h0, 32'h0010_0500},  // R8 lane 0
    '{1'b1, 8'h04, 32'h0,         4'h2, 32'h0},
    '{1'b0, 8'h04, 32'h0,         4'h0, 32'h0010_0000},  // R8 lane 1
    '{1'b1, 8'h00, 32'hFFFF_FFFF, 4'hF, 32'h0},
    '{1'b0, 8'h00, 32'h0,         4'h0, 32'hA5C3_1B2E},  // R2 read-only
    '{1'b0, 8'h08, 32'h0,         4'h0, 32'h0},          // R9
    '{1'b0, 8'h3C, 32'h0,         4'h0, 32'h0},          // R9
    '{1'b1, 8'h04, 32'h0000_0004, 4'h1, 32'h0},
    '{1'b0, 8'h04, 32'h0,         4'h0, 32'h0010_0004}   // R8
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = '0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic cpl_pulse(input logic [2:0] code);
    @(negedge clk);
    cpl_valid = 1'b1; cpl_status = code;
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 outputs after reset
    @(negedge clk);
    check("R1 outputs", {28'd0, intx_out, mem_en, bus_master_en, serr_en}, 32'h0);
    check("R10 idle rvalid", {31'd0, reg_rvalid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) do_write(VECS[i].addr, VECS[i].data, VECS[i].be);
      else begin
        do_read(VECS[i].addr, rd);
        check("R1 R2 R8 R9 vector", rd, VECS[i].exp);
        check("R10 rvalid", {31'd0, reg_rvalid}, 32'h1);
      end
    end
    check("R8 bus_master_en", {31'd0, bus_master_en}, 32'h1);
    check("R8 mem_en", {31'd0, mem_en}, 32'h0);
    @(negedge clk);
    check("R10 rvalid drops", {31'd0, reg_rvalid}, 32'h0);

    do_write(8'h04, 32'h0000_0100, 4'h2);
    check("R8 serr_en", {31'd0, serr_en}, 32'h1);
    do_write(8'h04, 32'h0, 4'h3);

    // R3 completions
    cpl_pulse(3'b000);
    do_read(8'h04, rd);
    check("R3 success sets none", rd, 32'h0010_0000);
    cpl_pulse(3'b001);
    do_read(8'h04, rd);
    check("R3 unsupported", rd, 32'h2010_0000);
    cpl_pulse(3'b100);
    do_read(8'h04, rd);
    check("R3 completer abort", rd, 32'h3010_0000);
    do_read(8'h04, rd);
    check("R11 fabric flags/cap", fab_rdata, 32'h0);

    // R4 write-1-to-clear
    do_write(8'h04, 32'h0000_0000, 4'hF);
    do_read(8'h04, rd);
    check("R4 write 0 keeps", rd, 32'h3010_0000);
    do_write(8'h04, 32'h3000_0000, 4'h7);
    do_read(8'h04, rd);
    check("R4 lane 3 off keeps", rd, 32'h3010_0000);
    do_write(8'h04, 32'h1000_0000, 4'h8);
    do_read(8'h04, rd);
    check("R4 clear bit 28", rd, 32'h2010_0000);

    // R5 set beats clear
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h04; reg_wdata = 32'h2000_0000; reg_be = 4'h8;
    cpl_valid = 1'b1; cpl_status = 3'b001;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = '0; cpl_valid = 1'b0;
    do_read(8'h04, rd);
    check("R5 set wins", rd, 32'h2010_0000);
    do_write(8'h04, 32'h2000_0000, 4'h8);
    do_read(8'h04, rd);
    check("R4 clear bit 29", rd, 32'h0010_0000);

    // R6 R7 interrupt
    @(negedge clk);
    irq_pending = 1'b1;
    @(negedge clk);
    check("R7 intx on", {31'd0, intx_out}, 32'h1);
    do_read(8'h04, rd);
    check("R6 status set", rd, 32'h0018_0000);
    do_write(8'h04, 32'h0000_0400, 4'h2);
    check("R7 intx masked", {31'd0, intx_out}, 32'h0);
    do_read(8'h04, rd);
    check("R6 status ignores disable", rd, 32'h0018_0400);
    check("R11 fabric cap off", fab_rdata, 32'h0008_0400);
    @(negedge clk);
    irq_pending = 1'b0;
    do_write(8'h04, 32'h0, 4'h2);
    check("R7 intx off with no request", {31'd0, intx_out}, 32'h0);
    do_read(8'h04, rd);
    check("R6 status clear", rd, 32'h0010_0000);

    // R1 reset again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_read(8'h04, rd);
    check("R1 reset value", rd, 32'h0010_0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule